// File: doc/BRIEF.md
# Flit-Grant Synchronization Unit

This block sits on one input of a two-stage bufferless router. Every packet that enters the router has its output port chosen before its flits reach the switch. This unit keeps those chosen port numbers in a small elastic queue of its own, next to the flit pipeline. Arrival order is preserved, so the entry at the head of the queue always belongs to the packet whose flits are next in line at the switch.

The head entry is shown to the output arbiters as a one-hot request vector. When the tail flit of the current packet leaves, the unit pops the head entry, so the next packet's port becomes the request. It also pulses an update strobe on every output. An arbiter that is granting this input uses that strobe to reload its grant registers at the following clock edge. If no other packet is waiting, the request vector goes to zero until a new port number is written. The arbiters and the flit data path are outside this block.

Top module: `flit_grant_sync`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is applied, and in the first cycle after it, `out_req` and `out_upd` are all zero, `pid_ready` is high and no port number is stored.
- R2: A port number accepted on an edge where both `pid_valid` and `pid_ready` are high is stored. If the queue was empty, it appears on `out_req` right after that edge.
- R3: `out_req` has at most one bit set. When a packet is stored, the set bit is the one whose index equals the head port number (bit k for port number k).
- R4: The queue holds at most `DEPTH` port numbers (3 by default). With `DEPTH` entries stored, `pid_ready` is low and a number offered with `pid_valid` is not stored.
- R5: A `tail_depart` pulse while a packet is stored removes the head entry. Right after that edge, `out_req` shows the next stored port number, and entries leave in the order they arrived.
- R6: A `tail_depart` pulse while a packet is stored makes every bit of `out_upd` high for exactly the one cycle after that edge. At all other times `out_upd` is all zero.
- R7: When the last stored entry is removed, `out_req` becomes zero. It stays zero until a new port number is accepted, and that number then appears as in R2.
- R8: A `tail_depart` pulse while nothing is stored has no effect: `out_upd` stays zero and `out_req` stays zero.
- R9: A push and a `tail_depart` on the same edge both take effect. The head advances, the new number joins the queue and the entry count stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pid_valid | input | 1 | A new packet's output port number is offered |
| pid_data | input | ID_W (3) | Output port number of the new packet, below PORTS |
| pid_ready | output | 1 | Queue has a free slot |
| tail_depart | input | 1 | The current packet's tail flit leaves the switch this cycle |
| out_req | output | PORTS (5) | One-hot request to the output arbiters |
| out_upd | output | PORTS (5) | Update strobe broadcast to all outputs |

## Verification
The bench fills the queue to its depth and offers one more port number while `pid_ready` is low. A design that stored the extra number would later show it as a request after the third departure. It sends a departure with an empty queue, where a careless design would pulse the update strobe or drift its pointers. It checks that removing the last entry leaves no stale request on `out_req`. It also applies a push and a departure on the same edge: a design that let one of them win would either show the wrong next port or lose the new packet.

// File: rtl/fgs_pkg.sv
package fgs_pkg;

    localparam int DEF_PORTS = 5;
    localparam int DEF_DEPTH = 3;

    // queue operation selected on one edge: {push, pop}
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } q_op_t;

    function automatic int id_width(input int ports);
        return (ports > 1) ? $clog2(ports) : 1;
    endfunction

endpackage

// File: rtl/pid_queue.sv
module pid_queue
    import fgs_pkg::*;
#(
    parameter int ID_W  = 3,
    parameter int DEPTH = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [ID_W-1:0] din,
    output logic [ID_W-1:0] head,
    output logic            empty,
    output logic            full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic [ID_W-1:0]  slot_q [DEPTH];
    logic             wr_en, rd_en;
    q_op_t            op;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign wr_en = push && !full;
    assign rd_en = pop && !empty;
    assign op    = q_op_t'({wr_en, rd_en});
    assign head  = slot_q[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [ID_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && wr_ptr == PTR_W'(g))
                q <= din;
        end
        assign slot_q[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    wr_ptr <= nxt(wr_ptr);
                    count  <= count + 1'b1;
                end
                OP_POP: begin
                    rd_ptr <= nxt(rd_ptr);
                    count  <= count - 1'b1;
                end
                OP_BOTH: begin
                    wr_ptr <= nxt(wr_ptr);
                    rd_ptr <= nxt(rd_ptr);
                end
                default: ;
            endcase
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_full_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);

    assert_push_pop_count_R9: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty && !full) |=> $stable(count));

    assert_empty_pop_inert_R8: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/req_decode.sv
module req_decode #(
    parameter int PORTS = 5,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic [ID_W-1:0]  id,
    output logic [PORTS-1:0] req
);
    for (genvar i = 0; i < PORTS; i++) begin : g_line
        assign req[i] = vld && (id == ID_W'(i));
    end

    assert_onehot_req_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req));
endmodule

// File: rtl/upd_pulse.sv
module upd_pulse #(
    parameter int PORTS = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    output logic [PORTS-1:0] upd
);
    logic [PORTS-1:0] upd_q;

    always_ff @(posedge clk) begin
        if (rst)
            upd_q <= '0;
        else
            upd_q <= {PORTS{fire}};
    end

    assign upd = upd_q;

    assert_upd_broadcast_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_q == '0) || (&upd_q));

    assert_upd_single_R6: assert property (@(posedge clk) disable iff (rst)
        (|upd_q && !fire) |=> (upd_q == '0));
endmodule

// File: rtl/flit_grant_sync.sv
module flit_grant_sync
    import fgs_pkg::*;
#(
    parameter int PORTS = DEF_PORTS,
    parameter int DEPTH = DEF_DEPTH,
    parameter int ID_W  = id_width(PORTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pid_valid,
    input  logic [ID_W-1:0]  pid_data,
    output logic             pid_ready,
    input  logic             tail_depart,
    output logic [PORTS-1:0] out_req,
    output logic [PORTS-1:0] out_upd
);
    logic [ID_W-1:0] head_id;
    logic            q_empty, q_full;

    pid_queue #(.ID_W(ID_W), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (pid_valid),
        .pop   (tail_depart),
        .din   (pid_data),
        .head  (head_id),
        .empty (q_empty),
        .full  (q_full)
    );

    req_decode #(.PORTS(PORTS), .ID_W(ID_W)) u_decode (
        .clk (clk),
        .rst (rst),
        .vld (!q_empty),
        .id  (head_id),
        .req (out_req)
    );

    upd_pulse #(.PORTS(PORTS)) u_upd (
        .clk  (clk),
        .rst  (rst),
        .fire (tail_depart && !q_empty),
        .upd  (out_upd)
    );

    assign pid_ready = !q_full;

    assert_idle_no_req_R7: assert property (@(posedge clk) disable iff (rst)
        q_empty |-> (out_req == '0));

    assert_upd_after_tail_R6: assert property (@(posedge clk) disable iff (rst)
        (|out_upd) |-> $past(tail_depart));

    assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pid_ready && out_req == '0 && out_upd == '0));
endmodule

// File: tb/flit_grant_sync_bench.sv
module flit_grant_sync_bench;
    localparam int PERIOD = 10;
    localparam int PORTS  = 5;
    localparam int ID_W   = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pid_valid = 1'b0;
    logic [ID_W-1:0]  pid_data = '0;
    logic             pid_ready;
    logic             tail_depart = 1'b0;
    logic [PORTS-1:0] out_req;
    logic [PORTS-1:0] out_upd;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    flit_grant_sync u_flit_grant_sync (
        .clk(clk), .rst(rst), .pid_valid(pid_valid), .pid_data(pid_data),
        .pid_ready(pid_ready), .tail_depart(tail_depart),
        .out_req(out_req), .out_upd(out_upd)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [PORTS-1:0] oh(input int id);
        return PORTS'(1) << id;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input int id);
        pid_valid = 1'b1;
        pid_data  = ID_W'(id);
        step();
        pid_valid = 1'b0;
    endtask

    task automatic pop();
        tail_depart = 1'b1;
        step();
        tail_depart = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        chk("R1 req in reset", 32'(out_req), 0);
        chk("R1 upd in reset", 32'(out_upd), 0);
        step();
        rst = 1'b0;
        step();
        chk("R1 req after reset", 32'(out_req), 0);
        chk("R1 ready after reset", 32'(pid_ready), 1);
    endtask

    task automatic t_single();
        push(2);
        chk("R2 first req", 32'(out_req), 32'(oh(2)));
        chk("R3 upd quiet on push", 32'(out_upd), 0);
        pop();
        chk("R7 req cleared", 32'(out_req), 0);
        chk("R6 upd on last pop", 32'(out_upd), 32'(5'h1f));
        step();
        chk("R6 upd one cycle", 32'(out_upd), 0);
    endtask

    task automatic t_fill_order();
        push(4);
        push(1);
        push(3);
        chk("R3 head stays first", 32'(out_req), 32'(oh(4)));
        chk("R4 ready low full", 32'(pid_ready), 0);
        push(0);
        chk("R4 req unchanged by blocked push", 32'(out_req), 32'(oh(4)));
        pop();
        chk("R5 second entry", 32'(out_req), 32'(oh(1)));
        chk("R6 upd broadcast", 32'(out_upd), 32'(5'h1f));
        chk("R4 ready after pop", 32'(pid_ready), 1);
        pop();
        chk("R5 third entry", 32'(out_req), 32'(oh(3)));
        pop();
        chk("R4 blocked number not stored", 32'(out_req), 0);
        step();
        chk("R6 upd clears", 32'(out_upd), 0);
    endtask

    task automatic t_empty_pop();
        pop();
        chk("R8 no upd on empty pop", 32'(out_upd), 0);
        chk("R8 req stays zero", 32'(out_req), 0);
        step();
        chk("R8 still no upd", 32'(out_upd), 0);
        push(4);
        chk("R7 new number after idle", 32'(out_req), 32'(oh(4)));
        pop();
        chk("R7 cleared again", 32'(out_req), 0);
        step();
    endtask

    task automatic t_simul();
        push(3);
        pid_valid   = 1'b1;
        pid_data    = ID_W'(1);
        tail_depart = 1'b1;
        step();
        pid_valid   = 1'b0;
        tail_depart = 1'b0;
        chk("R9 new head after push+pop", 32'(out_req), 32'(oh(1)));
        chk("R9 upd on push+pop", 32'(out_upd), 32'(5'h1f));
        chk("R9 ready", 32'(pid_ready), 1);
        pop();
        chk("R9 one entry remained", 32'(out_req), 0);
        step();
    endtask

    initial begin
        do_reset();
        t_single();
        t_fill_order();
        t_empty_pop();
        t_simul();
        do_reset();
        push(0);
        chk("R3 port zero bit", 32'(out_req), 32'(oh(0)));
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule